// File: doc/BRIEF.md
# Byte-Lane Control and Status Register Bank

This block is a bank of control and status registers that sits on a simple bus with an 8-bit data path. A logical register can be 1 to 64 bits wide. It is spread over as many byte-sized bus words as its width needs, and those words sit 4 address units apart. The bank answers only inside its own 2 KiB window. The window starts at a base address plus 0x800 times a bank index. Control registers come first in the window, in index order, and status registers follow them with no gap.

Control registers are written a byte at a time, from the most significant byte to the least. Each byte except the last goes into a shadow copy. The write of the last byte, which sits at the highest address of the register, moves the whole assembled value onto the control output in one step. Downstream logic therefore never sees a half-written multi-byte value. Status registers are read-only and show the hardware inputs. The bank also forwards one registered interrupt line and drives a constant interrupt number.

Top module: `csr_bank`

## Requirements
- R1: A bus access takes effect only when its address lies in [CSR_BASE + 0x800*BANK_IDX, that + 0x800). With the defaults this is 0x5800 to 0x5FFF. Reads outside the window return 0x00, and writes outside it change nothing.
- R2: Registers are laid out in this order: control registers 0..N_CTRL-1, then status registers 0..N_STAT-1. A register of W bits takes ceil(W/8) words, and successive words sit 4 apart. The default map is: control 0 (32 bits) at 0x00–0x0C, control 1 (12 bits) at 0x10–0x14, status 0 (16 bits) at 0x18–0x1C, and status 1 (40 bits) at 0x20–0x30.
- R3: Within a register, the lowest address holds the most significant byte, and each higher address holds the next less significant byte.
- R4: A write to any byte of a control register except its last (highest address) byte leaves ctrl_o unchanged. A write to the last byte loads the full value on the next clock edge. That value is the most recent shadowed bytes plus the new byte.
- R5: A read of a control register returns its committed value and never the shadowed bytes.
- R6: Bits at or above a register's width W read as zero. They are dropped on writes, and any such bits on a status input are ignored.
- R7: A read of a status register returns the stat_i byte present at the clock edge that takes the read. Writes to status addresses have no effect on ctrl_o or on any later read.
- R8: Inside the window, a read of an address past the last register, or of an address with bits [1:0] not zero, returns 0x00. A write to such an address changes nothing, including the shadow bytes.
- R9: bus_rdata is registered. It carries the read byte in the cycle after the read request and is 0x00 in any cycle that follows a cycle with no read.
- R10: irq_o equals irq_src_i delayed by one clock, and irq_num_o is constant at IRQ_NUM (default 5).
- R11: After reset, ctrl_o, all shadow bytes, bus_rdata and irq_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, one cycle after the request |
| ctrl_o | output | N_CTRL*64 (128) | Committed control values, one 64-bit slot per register, register 0 in the low slot |
| stat_i | input | N_STAT*64 (128) | Status values, one 64-bit slot per register |
| irq_src_i | input | 1 | Interrupt source level |
| irq_o | output | 1 | Registered interrupt line |
| irq_num_o | output | IRQ_W (5) | Fixed interrupt number |

## Verification
Two kinds of event can land on the same clock edge. First, a status input can change on the same edge that takes a read of that status register. Second, the interrupt source can toggle in the same cycle as a control commit. The bench drives the new stat_i value in the same half-cycle as the read request. It expects the byte of the new value, and it checks the interrupt lag and the commit together in one cycle. A behavioural reference model then runs next to the design through several thousand cycles of mixed random traffic, with stat_i and irq_src_i changing every cycle. It compares ctrl_o, bus_rdata and irq_o on every clock.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int MAX_BYTES   = 8;
  localparam int SLOT_W      = MAX_BYTES * 8;
  localparam int WORD_STRIDE = 4;
  localparam int BANK_SPAN   = 'h800;

  // Number of byte words a register of w bits occupies.
  function automatic int bytes_for(input int w);
    return (w + 7) / 8;
  endfunction

  // Mask of the low w bits of a slot.
  function automatic logic [SLOT_W-1:0] width_mask(input int w);
    logic [SLOT_W-1:0] m;
    for (int i = 0; i < SLOT_W; i++) m[i] = (i < w);
    return m;
  endfunction

  // Bit position of byte idx in an nb-byte register, most significant byte first.
  function automatic logic [5:0] byte_pos(input int nb, input int idx);
    return 6'((nb - 1 - idx) * 8);
  endfunction
endpackage

// File: rtl/csr_decode.sv
module csr_decode import csr_pkg::*; #(
  parameter int ADDR_W   = 16,
  parameter int CSR_BASE = 'h4000,
  parameter int BANK_IDX = 3,
  parameter int WORD_W   = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_bank,
  output logic              aligned,
  output logic [WORD_W-1:0] word_idx
);
  localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(CSR_BASE + BANK_SPAN * BANK_IDX);
  localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(BANK_SPAN);

  logic [ADDR_W-1:0] rel;

  assign rel      = addr - BANK_LO;
  assign in_bank  = (addr >= BANK_LO) && (rel < SPAN);
  assign aligned  = (rel[1:0] == 2'b00);
  assign word_idx = rel[WORD_W+1:2];
endmodule

// File: rtl/csr_ctrl_reg.sv
module csr_ctrl_reg import csr_pkg::*; #(
  parameter int W         = 32,
  parameter int BASE_WORD = 0,
  parameter int WORD_W    = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ok,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] word_idx,
  input  logic [7:0]        wdata,
  output logic              hit,
  output logic [7:0]        rd_byte,
  output logic [SLOT_W-1:0] value
);
  localparam int                NB   = bytes_for(W);
  localparam logic [SLOT_W-1:0] MASK = width_mask(W);
  localparam logic [WORD_W-1:0] LO   = WORD_W'(BASE_WORD);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(NB - 1);

  logic [WORD_W-1:0] off;
  logic [5:0]        pos;
  logic              commit;
  logic              stage;
  logic [SLOT_W-1:0] shadow;

  assign off    = word_idx - LO;
  assign hit    = acc_ok && (word_idx >= LO) && (off <= LAST);
  assign pos    = byte_pos(NB, int'(off));
  assign commit = hit && wr_en && (off == LAST);
  assign stage  = hit && wr_en && (off != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value  <= '0;
      shadow <= '0;
    end else begin
      if (stage)  shadow[pos +: 8] <= wdata;
      if (commit) value <= ((shadow & ~SLOT_W'(8'hFF)) | SLOT_W'(wdata)) & MASK;
    end
  end

  assign rd_byte = hit ? 8'(value >> pos) : 8'h00;

  AST_HOLD_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(value)); // R4
  AST_LAST_BYTE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (value[7:0] == ($past(wdata) & MASK[7:0]))); // R4
endmodule

// File: rtl/csr_stat_reg.sv
module csr_stat_reg import csr_pkg::*; #(
  parameter int W         = 16,
  parameter int BASE_WORD = 0,
  parameter int WORD_W    = 9
) (
  input  logic              acc_ok,
  input  logic [WORD_W-1:0] word_idx,
  input  logic [SLOT_W-1:0] stat_in,
  output logic              hit,
  output logic [7:0]        rd_byte
);
  localparam int                NB   = bytes_for(W);
  localparam logic [SLOT_W-1:0] MASK = width_mask(W);
  localparam logic [WORD_W-1:0] LO   = WORD_W'(BASE_WORD);
  localparam logic [WORD_W-1:0] LAST = WORD_W'(NB - 1);

  logic [WORD_W-1:0] off;
  logic [5:0]        pos;
  logic [SLOT_W-1:0] masked;

  assign off     = word_idx - LO;
  assign hit     = acc_ok && (word_idx >= LO) && (off <= LAST);
  assign pos     = byte_pos(NB, int'(off));
  assign masked  = stat_in & MASK;
  assign rd_byte = hit ? 8'(masked >> pos) : 8'h00;
endmodule

// File: rtl/csr_bank.sv
module csr_bank import csr_pkg::*; #(
  parameter int ADDR_W          = 16,
  parameter int CSR_BASE        = 'h4000,
  parameter int BANK_IDX        = 3,
  parameter int N_CTRL          = 2,
  parameter int N_STAT          = 2,
  parameter int CTRL_W [N_CTRL] = '{32, 12},
  parameter int STAT_W [N_STAT] = '{16, 40},
  parameter int HAS_IRQ         = 1,
  parameter int IRQ_NUM         = 5,
  parameter int IRQ_W           = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [7:0]               bus_wdata,
  output logic [7:0]               bus_rdata,
  output logic [N_CTRL*SLOT_W-1:0] ctrl_o,
  input  logic [N_STAT*SLOT_W-1:0] stat_i,
  input  logic                     irq_src_i,
  output logic                     irq_o,
  output logic [IRQ_W-1:0]         irq_num_o
);
  localparam int WORD_W = $clog2(BANK_SPAN / WORD_STRIDE);

  function automatic int ctrl_base(input int k);
    int s = 0;
    for (int j = 0; j < k; j++) s += bytes_for(CTRL_W[j]);
    return s;
  endfunction

  function automatic int stat_base(input int k);
    int s = ctrl_base(N_CTRL);
    for (int j = 0; j < k; j++) s += bytes_for(STAT_W[j]);
    return s;
  endfunction

  // Named internal events for the assertions.
  logic              in_bank, aligned, acc_ok, rd_req, wr_req, any_hit;
  logic [WORD_W-1:0] word_idx;
  logic [N_CTRL-1:0] ctrl_hit;
  logic [N_STAT-1:0] stat_hit;
  logic [7:0]        ctrl_rd [N_CTRL];
  logic [7:0]        stat_rd [N_STAT];
  logic [7:0]        rd_mux;
  logic [7:0]        rdata_q;

  csr_decode #(
    .ADDR_W(ADDR_W), .CSR_BASE(CSR_BASE), .BANK_IDX(BANK_IDX), .WORD_W(WORD_W)
  ) u_dec (
    .addr(bus_addr), .in_bank(in_bank), .aligned(aligned), .word_idx(word_idx)
  );

  assign acc_ok = bus_valid && in_bank && aligned;
  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid && bus_write;

  for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
    csr_ctrl_reg #(
      .W(CTRL_W[k]), .BASE_WORD(ctrl_base(k)), .WORD_W(WORD_W)
    ) u_reg (
      .clk(clk), .rst_n(rst_n), .acc_ok(acc_ok), .wr_en(wr_req),
      .word_idx(word_idx), .wdata(bus_wdata), .hit(ctrl_hit[k]),
      .rd_byte(ctrl_rd[k]), .value(ctrl_o[k*SLOT_W +: SLOT_W])
    );
  end

  for (genvar k = 0; k < N_STAT; k++) begin : g_stat
    csr_stat_reg #(
      .W(STAT_W[k]), .BASE_WORD(stat_base(k)), .WORD_W(WORD_W)
    ) u_reg (
      .acc_ok(acc_ok), .word_idx(word_idx), .stat_in(stat_i[k*SLOT_W +: SLOT_W]),
      .hit(stat_hit[k]), .rd_byte(stat_rd[k])
    );
  end

  assign any_hit = (|ctrl_hit) || (|stat_hit);

  always_comb begin
    rd_mux = 8'h00;
    for (int k = 0; k < N_CTRL; k++) rd_mux |= ctrl_rd[k];
    for (int k = 0; k < N_STAT; k++) rd_mux |= stat_rd[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= 8'h00;
    else        rdata_q <= rd_req ? rd_mux : 8'h00;
  end
  assign bus_rdata = rdata_q;

  if (HAS_IRQ != 0) begin : g_irq
    logic irq_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_src_i;
    end
    assign irq_o     = irq_q;
    assign irq_num_o = IRQ_W'(IRQ_NUM);

    AST_IRQ_RISE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_src_i |=> irq_o); // R10
    AST_IRQ_FALL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_src_i |=> !irq_o); // R10
  end else begin : g_noirq
    assign irq_o     = 1'b0;
    assign irq_num_o = '0;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_hit, stat_hit})); // R2
  AST_OUTSIDE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !in_bank) |-> !any_hit); // R1
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !any_hit) |=> (bus_rdata == 8'h00)); // R8
  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (bus_rdata == 8'h00)); // R9
  AST_STAT_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && (|stat_hit)) |=> $stable(ctrl_o)); // R7
endmodule

// File: tb/csr_bank_tb.sv
module csr_bank_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid, bus_write;
  logic [15:0]  bus_addr;
  logic [7:0]   bus_wdata, bus_rdata;
  logic [127:0] ctrl_o, stat_i;
  logic         irq_src_i, irq_o;
  logic [4:0]   irq_num_o;

  always #5 clk = ~clk;

  csr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_o(ctrl_o), .stat_i(stat_i), .irq_src_i(irq_src_i), .irq_o(irq_o),
    .irq_num_o(irq_num_o)
  );

  localparam logic [15:0] WIN = 16'h5800;
  int    regw [4] = '{32, 12, 16, 40};
  int    n_run = 0, n_fail = 0;
  bit    done = 0;
  string phase = "R11";

  // ---------------- reference model ----------------
  logic [63:0] m_ctrl [2];
  logic [7:0]  m_sh [2][8];
  logic [7:0]  m_rdata;
  logic        m_irq;

  function automatic logic [63:0] wmask(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [7:0] byte_of(input logic [63:0] v, input int nb, input int b);
    logic [63:0] t;
    t = v >> (8 * (nb - 1 - b));
    return t[7:0];
  endfunction

  function automatic void locate(input logic [15:0] a, output int r, output int b);
    int w, first;
    r = -1; b = 0; first = 0;
    if (a < WIN || a >= WIN + 16'h0800 || a[1:0] != 2'b00) return;
    w = int'(a - WIN) / 4;
    for (int k = 0; k < 4; k++) begin
      int nb;
      nb = (regw[k] + 7) / 8;
      if (r < 0 && w >= first && w < first + nb) begin r = k; b = w - first; end
      first += nb;
    end
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) begin
        m_ctrl[k] = '0;
        for (int i = 0; i < 8; i++) m_sh[k][i] = 8'h00;
      end
      m_rdata = 8'h00;
      m_irq   = 1'b0;
    end else begin
      int r, b, nb;
      logic [63:0] v;
      m_irq   = irq_src_i;
      m_rdata = 8'h00;
      if (bus_valid) begin
        locate(bus_addr, r, b);
        nb = (r >= 0) ? (regw[r] + 7) / 8 : 0;
        if (!bus_write) begin
          if (r >= 0 && r < 2) m_rdata = byte_of(m_ctrl[r], nb, b);
          else if (r >= 2)     m_rdata = byte_of(stat_i[(r-2)*64 +: 64] & wmask(regw[r]), nb, b);
        end else if (r >= 0 && r < 2) begin
          if (b == nb - 1) begin
            v = 64'(bus_wdata);
            for (int i = 0; i < nb - 1; i++) v |= 64'(m_sh[r][i]) << (8 * (nb - 1 - i));
            m_ctrl[r] = v & wmask(regw[r]);
          end else begin
            m_sh[r][b] = bus_wdata;
          end
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  task automatic report(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      report({phase, " ctrl_o model"}, ctrl_o, {m_ctrl[1], m_ctrl[0]});
      report({phase, " R9 rdata model"}, 128'(bus_rdata), 128'(m_rdata));
      report({phase, " R10 irq model"}, 128'(irq_o), 128'(m_irq));
    end
  end

  // ---------------- bus tasks (called at a negedge) ----------------
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    report(tag, act, exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] x;
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    stat_i = '0; irq_src_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 ctrl_o", ctrl_o, 0);
    chk("R11 rdata", 128'(bus_rdata), 0);
    chk("R11 irq_o", 128'(irq_o), 0);

    phase = "R4";
    wr(16'h5800, 8'h12); wr(16'h5804, 8'h34); wr(16'h5808, 8'h56);
    chk("R4 held before last byte", ctrl_o[63:0], 0);
    wr(16'h580C, 8'h78);
    chk("R4 commit", ctrl_o[63:0], 64'h12345678);
    phase = "R3";
    rd(16'h5800, x); chk("R3 msb at low addr", 128'(x), 8'h12);
    rd(16'h5808, x); chk("R3 byte 2", 128'(x), 8'h56);
    rd(16'h580C, x); chk("R3 lsb at high addr", 128'(x), 8'h78);
    phase = "R9";
    @(negedge clk);
    chk("R9 idle rdata", 128'(bus_rdata), 0);

    phase = "R5";
    wr(16'h5800, 8'hAA); wr(16'h5804, 8'hBB);
    rd(16'h5800, x); chk("R5 read gives committed", 128'(x), 8'h12);
    chk("R5 ctrl unchanged", ctrl_o[63:0], 64'h12345678);
    wr(16'h580C, 8'h01);
    chk("R4 commit with older shadow", ctrl_o[63:0], 64'hAABB5601);

    phase = "R6";
    wr(16'h5810, 8'hFF); wr(16'h5814, 8'hAB);
    chk("R6 width mask ctrl1", ctrl_o[127:64], 64'h0FAB);
    rd(16'h5810, x); chk("R6 upper bits read zero", 128'(x), 8'h0F);

    phase = "R7";
    stat_i = {64'hFFFF_FFAB_CDEF_0123, 64'hFFFF_FFFF_FFFF_BEEF};
    rd(16'h5818, x); chk("R7 stat0 msb", 128'(x), 8'hBE);
    rd(16'h581C, x); chk("R7 stat0 lsb", 128'(x), 8'hEF);
    rd(16'h5820, x); chk("R6 stat1 top byte masked", 128'(x), 8'hAB);
    rd(16'h5830, x); chk("R2 stat1 last word", 128'(x), 8'h23);
    wr(16'h5818, 8'h55); wr(16'h5830, 8'h66);
    chk("R7 stat write inert", ctrl_o, {64'h0FAB, 64'hAABB5601});
    rd(16'h5818, x); chk("R7 stat still input", 128'(x), 8'hBE);
    // status input changes on the very edge that takes the read
    bus_valid = 1; bus_write = 0; bus_addr = 16'h581C;
    stat_i[63:0] = 64'h0000_0000_0000_1357;
    @(negedge clk); x = bus_rdata; bus_valid = 0;
    chk("R7 same-edge status value", 128'(x), 8'h57);

    phase = "R8";
    rd(16'h5834, x); chk("R8 past last register", 128'(x), 0);
    rd(16'h5801, x); chk("R8 misaligned read", 128'(x), 0);
    rd(16'h5FFC, x); chk("R8 window end", 128'(x), 0);
    wr(16'h5801, 8'h99); wr(16'h5802, 8'h98);
    chk("R8 misaligned write inert", ctrl_o[63:0], 64'hAABB5601);
    wr(16'h580C, 8'h02);
    chk("R8 shadow untouched", ctrl_o[63:0], 64'hAABB5602);

    phase = "R1";
    wr(16'h5000, 8'h77); wr(16'h500C, 8'h77); wr(16'h600C, 8'h77); wr(16'h780C, 8'h77);
    chk("R1 other bank writes inert", ctrl_o[63:0], 64'hAABB5602);
    rd(16'h6000, x); chk("R1 above window", 128'(x), 0);
    rd(16'h57FC, x); chk("R1 below window", 128'(x), 0);
    wr(16'h580C, 8'h03);
    chk("R1 no shadow leak", ctrl_o[63:0], 64'hAABB5603);

    phase = "R10";
    chk("R10 irq number", 128'(irq_num_o), 5);
    irq_src_i = 1;
    wr(16'h5814, 8'h11);
    chk("R10 irq rise with commit", 128'(irq_o), 1);
    chk("R4 commit same cycle as irq", ctrl_o[127:64], 64'h0F11);
    irq_src_i = 0;
    @(negedge clk);
    chk("R10 irq fall", 128'(irq_o), 0);

    phase = "R2 random";
    for (int i = 0; i < 4000; i++) begin
      int mode;
      mode = int'($urandom % 8);
      bus_valid = ($urandom % 4) != 0;
      bus_write = $urandom % 2;
      bus_wdata = 8'($urandom);
      stat_i    = {$urandom, $urandom, $urandom, $urandom};
      irq_src_i = $urandom % 2;
      if (mode == 0)      bus_addr = 16'($urandom);
      else if (mode == 1) bus_addr = WIN + 16'($urandom % 64);
      else                bus_addr = WIN + 16'(4 * ($urandom % 16));
      @(negedge clk);
    end
    bus_valid = 0;
    @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule